// File: doc/BRIEF.md
# Sub-bank remapping refresh controller

This block schedules refresh for one DRAM bank that is cut into equal, disjoint sub-banks, and it translates row addresses for that bank. Each sub-bank owns a control word. When the word is valid it names one weak row, a row with retention faults, inside that sub-bank. The translator swaps that row with the last row slot of the sub-bank, so the weak data always lives in the bottom slot.

The scheduler has two streams, both timed by a tick input. The fast stream refreshes only bottom slots, one sub-bank after another. The normal stream walks every other row at an extended interval, which is a whole-number multiple of the fast interval. Software writes the control words through a simple write port. The array model, retention profiling and command bus timing are outside the block.

Top module: `srr_ctrl`

## Requirements
- R1: After reset `ref_vld_o` and `xlat_vld_o` are 0 and every control word is invalid, so translation returns the requested row unchanged.
- R2: While a sub-bank's control word is invalid, a translated row in that sub-bank comes out unchanged.
- R3: With a valid word naming in-sub-bank index w, a request for offset w returns the bottom offset SUB_ROWS-1 of the same sub-bank. Row address = {sub-bank, offset}, with the offset in the low log2(SUB_ROWS) bits.
- R4: With a valid word naming index w, a request for the bottom offset returns offset w. If w equals the bottom offset, the row is returned unchanged.
- R5: The sub-bank field of a translated row always equals that of the request. Offsets other than w and the bottom pass through unchanged, and so do rows of other sub-banks.
- R6: `xlat_vld_o` and `xlat_row_o` appear exactly one clock after the request is sampled.
- R7: Every FAST_INTV ticks a fast refresh is issued with `ref_fast_o`=1. It targets the bottom slot of sub-banks 0,1,2,… in turn and wraps after the last sub-bank.
- R8: Every FAST_INTV*EXT_MULT ticks a normal refresh is issued with `ref_fast_o`=0. It walks the non-bottom rows in ascending row order, never hits a bottom slot, and wraps after the last one.
- R9: When fast and normal refreshes fall due on the same tick, the fast one is issued first and the normal one in the very next clock.
- R10: A control word write with the valid bit at 0 removes that sub-bank's redirection, and a write to one sub-bank leaves all others unchanged. A write affects translations requested in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_sub_i | input | log2(NUM_SUB) | Sub-bank whose control word is written |
| cfg_valid_i | input | 1 | Valid bit of the written control word |
| cfg_idx_i | input | log2(SUB_ROWS) | Weak row index inside the sub-bank |
| xlat_req_i | input | 1 | Translation request |
| xlat_row_i | input | log2(NUM_SUB*SUB_ROWS) | Logical row to translate |
| xlat_vld_o | output | 1 | Translation result valid |
| xlat_row_o | output | log2(NUM_SUB*SUB_ROWS) | Physical row |
| tick_i | input | 1 | Refresh time base pulse |
| ref_vld_o | output | 1 | Refresh command valid |
| ref_fast_o | output | 1 | 1: fast (bottom slot) refresh, 0: normal refresh |
| ref_row_o | output | log2(NUM_SUB*SUB_ROWS) | Physical row to refresh |

## Verification
The fast and normal refresh streams can fall due on the same tick. In this scheduler every normal due coincides with a fast due, so each extended interval provokes the collision. The bench drives a long run of spaced ticks and queues the commands it expects, with the fast command ahead of the normal one. The monitor checks the order and the kind of each command, and it also checks that each normal command comes in the clock right after a fast one.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic {
    REF_NORM = 1'b0,
    REF_FAST = 1'b1
  } ref_kind_e;
endpackage

// File: rtl/srr_remap.sv
module srr_remap #(
  parameter int NUM_SUB  = 4,
  parameter int SUB_ROWS = 8,
  localparam int SUB_W = $clog2(NUM_SUB),
  localparam int OFF_W = $clog2(SUB_ROWS),
  localparam int ROW_W = SUB_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SUB_W-1:0] cfg_sub_i,
  input  logic             cfg_valid_i,
  input  logic [OFF_W-1:0] cfg_idx_i,
  input  logic             xlat_req_i,
  input  logic [ROW_W-1:0] xlat_row_i,
  output logic             xlat_vld_o,
  output logic [ROW_W-1:0] xlat_row_o
);
  localparam logic [OFF_W-1:0] BOT = OFF_W'(SUB_ROWS - 1);

  logic             cw_vld_q [NUM_SUB];
  logic [OFF_W-1:0] cw_idx_q [NUM_SUB];

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_cw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cw_vld_q[s] <= 1'b0;
        cw_idx_q[s] <= '0;
      end else if (cfg_we_i && cfg_sub_i == SUB_W'(s)) begin
        cw_vld_q[s] <= cfg_valid_i;
        cw_idx_q[s] <= cfg_idx_i;
      end
    end
  end

  logic [SUB_W-1:0] in_sub;
  logic [OFF_W-1:0] in_off, map_off;

  always_comb begin
    in_sub  = xlat_row_i[ROW_W-1:OFF_W];
    in_off  = xlat_row_i[OFF_W-1:0];
    map_off = in_off;
    if (cw_vld_q[in_sub]) begin
      if (in_off == cw_idx_q[in_sub])  map_off = BOT;
      else if (in_off == BOT)          map_off = cw_idx_q[in_sub];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xlat_vld_o <= 1'b0;
      xlat_row_o <= '0;
    end else begin
      xlat_vld_o <= xlat_req_i;
      if (xlat_req_i) xlat_row_o <= {in_sub, map_off};
    end
  end

  // R6
  xlat_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlat_req_i |=> xlat_vld_o);

  // R5
  xlat_sub_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlat_req_i |=> xlat_row_o[ROW_W-1:OFF_W] == $past(xlat_row_i[ROW_W-1:OFF_W]));
endmodule

// File: rtl/srr_sched.sv
module srr_sched
  import srr_pkg::*;
#(
  parameter int NUM_SUB   = 4,
  parameter int SUB_ROWS  = 8,
  parameter int FAST_INTV = 4,
  parameter int EXT_MULT  = 2,
  localparam int SUB_W = $clog2(NUM_SUB),
  localparam int OFF_W = $clog2(SUB_ROWS),
  localparam int ROW_W = SUB_W + OFF_W,
  localparam int FC_W  = $clog2(FAST_INTV),
  localparam int EC_W  = (EXT_MULT > 1) ? $clog2(EXT_MULT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic             ref_vld_o,
  output logic             ref_fast_o,
  output logic [ROW_W-1:0] ref_row_o
);
  localparam logic [OFF_W-1:0] BOT = OFF_W'(SUB_ROWS - 1);

  logic [FC_W-1:0]  fast_cnt_q;
  logic [EC_W-1:0]  ext_cnt_q;
  logic             fast_pend_q, norm_pend_q;
  logic [SUB_W-1:0] fast_sub_q, norm_sub_q;
  logic [OFF_W-1:0] norm_off_q;
  logic             fast_due, norm_due, issue_fast, issue_norm;
  ref_kind_e        kind;

  assign fast_due   = tick_i && fast_cnt_q == FC_W'(FAST_INTV - 1);
  assign norm_due   = fast_due && ext_cnt_q == EC_W'(EXT_MULT - 1);
  assign issue_fast = fast_pend_q;
  assign issue_norm = norm_pend_q && !fast_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_cnt_q  <= '0;
      ext_cnt_q   <= '0;
      fast_pend_q <= 1'b0;
      norm_pend_q <= 1'b0;
      fast_sub_q  <= '0;
      norm_sub_q  <= '0;
      norm_off_q  <= '0;
    end else begin
      if (tick_i) fast_cnt_q <= fast_due ? '0 : fast_cnt_q + 1'b1;
      if (fast_due) ext_cnt_q <= norm_due ? '0 : ext_cnt_q + 1'b1;
      fast_pend_q <= fast_due;
      norm_pend_q <= norm_due | (norm_pend_q & ~issue_norm);
      if (issue_fast)
        fast_sub_q <= (fast_sub_q == SUB_W'(NUM_SUB - 1)) ? '0 : fast_sub_q + 1'b1;
      if (issue_norm) begin
        if (norm_off_q == BOT - 1'b1) begin
          norm_off_q <= '0;
          norm_sub_q <= (norm_sub_q == SUB_W'(NUM_SUB - 1)) ? '0 : norm_sub_q + 1'b1;
        end else begin
          norm_off_q <= norm_off_q + 1'b1;
        end
      end
    end
  end

  assign kind       = fast_pend_q ? REF_FAST : REF_NORM;
  assign ref_vld_o  = fast_pend_q | norm_pend_q;
  assign ref_fast_o = (kind == REF_FAST);
  assign ref_row_o  = (kind == REF_FAST) ? {fast_sub_q, BOT} : {norm_sub_q, norm_off_q};

  // R9
  collide_fast_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_due |=> ref_vld_o && ref_fast_o);

  // R9
  collide_norm_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_vld_o && ref_fast_o && norm_pend_q) |=> ref_vld_o && !ref_fast_o);
endmodule

// File: rtl/srr_ctrl.sv
module srr_ctrl #(
  parameter int NUM_SUB   = 4,
  parameter int SUB_ROWS  = 8,
  parameter int FAST_INTV = 4,
  parameter int EXT_MULT  = 2,
  localparam int SUB_W = $clog2(NUM_SUB),
  localparam int OFF_W = $clog2(SUB_ROWS),
  localparam int ROW_W = SUB_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SUB_W-1:0] cfg_sub_i,
  input  logic             cfg_valid_i,
  input  logic [OFF_W-1:0] cfg_idx_i,
  input  logic             xlat_req_i,
  input  logic [ROW_W-1:0] xlat_row_i,
  output logic             xlat_vld_o,
  output logic [ROW_W-1:0] xlat_row_o,
  input  logic             tick_i,
  output logic             ref_vld_o,
  output logic             ref_fast_o,
  output logic [ROW_W-1:0] ref_row_o
);
  srr_remap #(.NUM_SUB(NUM_SUB), .SUB_ROWS(SUB_ROWS)) u_remap (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sub_i, .cfg_valid_i, .cfg_idx_i,
    .xlat_req_i, .xlat_row_i, .xlat_vld_o, .xlat_row_o
  );

  srr_sched #(.NUM_SUB(NUM_SUB), .SUB_ROWS(SUB_ROWS),
              .FAST_INTV(FAST_INTV), .EXT_MULT(EXT_MULT)) u_sched (
    .clk_i, .rst_ni, .tick_i, .ref_vld_o, .ref_fast_o, .ref_row_o
  );

  // R7
  fast_hits_bottom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_vld_o && ref_fast_o) |-> ref_row_o[OFF_W-1:0] == OFF_W'(SUB_ROWS - 1));

  // R8
  norm_skips_bottom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_vld_o && !ref_fast_o) |-> ref_row_o[OFF_W-1:0] != OFF_W'(SUB_ROWS - 1));
endmodule

// File: tb/srr_ctrl_bench.sv
module srr_ctrl_bench;
  localparam int NS = 4, SR = 8, FI = 4, EM = 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_we = 0, cfg_valid = 0, xlat_req = 0, tick = 0;
  logic [1:0] cfg_sub = 0;
  logic [2:0] cfg_idx = 0;
  logic [4:0] xlat_row = 0;
  logic       xlat_vld, ref_vld, ref_fast;
  logic [4:0] xlat_out, ref_row;

  int checks = 0, errors = 0;
  int xq[$];
  int rq[$];
  string xtag[$];
  logic prev_fast = 0;

  always #10 clk = ~clk;

  srr_ctrl #(.NUM_SUB(NS), .SUB_ROWS(SR), .FAST_INTV(FI), .EXT_MULT(EM)) u_srr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sub_i(cfg_sub),
    .cfg_valid_i(cfg_valid), .cfg_idx_i(cfg_idx), .xlat_req_i(xlat_req),
    .xlat_row_i(xlat_row), .xlat_vld_o(xlat_vld), .xlat_row_o(xlat_out),
    .tick_i(tick), .ref_vld_o(ref_vld), .ref_fast_o(ref_fast), .ref_row_o(ref_row)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cfg(input int sub, input bit vld, input int idx);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sub = 2'(sub); cfg_valid = vld; cfg_idx = 3'(idx);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic do_xlat(input int row, input int exp, input string req);
    @(posedge clk); #1;
    xlat_req = 1; xlat_row = 5'(row);
    xq.push_back(exp); xtag.push_back(req);
    @(posedge clk); #1;
    xlat_req = 0;
  endtask

  // bench model of the refresh streams
  int m_fc = 0, m_ec = 0, m_fs = 0, m_ns = 0, m_no = 0;
  task automatic do_tick();
    @(posedge clk); #1;
    tick = 1;
    if (m_fc == FI - 1) begin
      m_fc = 0;
      rq.push_back(64 + m_fs * SR + SR - 1);
      m_fs = (m_fs + 1) % NS;
      if (m_ec == EM - 1) begin
        m_ec = 0;
        rq.push_back(m_ns * SR + m_no);
        if (m_no == SR - 2) begin m_no = 0; m_ns = (m_ns + 1) % NS; end
        else m_no++;
      end else m_ec++;
    end else m_fc++;
    @(posedge clk); #1;
    tick = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (xlat_vld) begin
        if (xq.size() == 0) chk(0, "R6 unexpected xlat", int'(xlat_out), -1);
        else begin
          int e;
          string t;
          e = xq.pop_front(); t = xtag.pop_front();
          chk(int'(xlat_out) == e, t, int'(xlat_out), e);
        end
      end
      if (ref_vld) begin
        if (rq.size() == 0) chk(0, "R7 unexpected refresh", int'(ref_row), -1);
        else begin
          int e, a;
          e = rq.pop_front();
          a = (ref_fast ? 64 : 0) + int'(ref_row);
          chk(a == e, ref_fast ? "R7 fast refresh" : "R8 normal refresh", a, e);
          if (!ref_fast) chk(prev_fast, "R9 normal right after fast", int'(prev_fast), 1);
        end
      end
      prev_fast = ref_vld && ref_fast;
    end
  end

  initial begin
    #(20 * 100000);
    chk(0, "watchdog all reqs", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk(ref_vld == 0, "R1 ref_vld in reset", int'(ref_vld), 0);
    chk(xlat_vld == 0, "R1 xlat_vld in reset", int'(xlat_vld), 0);
    @(posedge clk); #1;
    rst_n = 1;
    // R1 / R2 identity after reset
    do_xlat(11, 11, "R1 identity after reset");
    do_xlat(15, 15, "R2 bottom passes invalid word");
    do_xlat(0, 0, "R2 row 0");
    // R3 / R4 / R5
    do_cfg(1, 1, 3);
    do_xlat(11, 15, "R3 weak to bottom");
    do_xlat(15, 11, "R4 bottom to weak");
    do_xlat(13, 13, "R5 other offset");
    do_xlat(19, 19, "R5 other sub-bank same offset");
    do_xlat(31, 31, "R5 other sub-bank bottom");
    do_cfg(2, 1, 7);
    do_xlat(23, 23, "R4 weak equals bottom");
    do_xlat(11, 15, "R10 sub-bank 1 untouched by write to 2");
    do_cfg(1, 0, 3);
    do_xlat(11, 11, "R10 cleared word");
    do_xlat(15, 15, "R10 cleared word bottom");
    do_cfg(3, 1, 0);
    do_xlat(24, 31, "R3 index 0 in sub-bank 3");
    do_xlat(31, 24, "R4 bottom of sub-bank 3");
    // refresh streams, including wrap of both walks
    for (int i = 0; i < 240; i++) begin
      do_tick();
      @(posedge clk);
    end
    repeat (6) @(posedge clk);
    #5;
    chk(rq.size() == 0, "R7 R8 all refreshes seen", rq.size(), 0);
    chk(xq.size() == 0, "R6 all translations seen", xq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule